// File: doc/BRIEF.md
# Sequential-RAM Mersenne Twister Random Word Generator

This block produces a stream of uniformly distributed 32-bit random words using the MT19937 recurrence. Its 624-word state lives in a single simple dual-port RAM rather than in parallel registers. After reset the block first fills the state from a seed value, one word per clock. It then walks the RAM index by index without end. Each index gets one read-modify-write that produces a new state word and a tempered output word.

The seed is taken from `seed_i` while reset is held low. The value present in the last reset cycle is the one used. `ready_o` rises when seeding ends. From then on `valid_o` marks every third cycle, and `data_o` carries the new word at that time. The only way to change the seed is to reset the block again.

Top module: `mt19937_gen`

## Requirements
- R1: While `rst_n` is low, `ready_o` and `valid_o` are 0 and `data_o` is 0.
- R2: After `rst_n` rises, the block writes all 624 state words from the seed. The first word equals the seed, and word k equals `1812433253 * (w[k-1] ^ (w[k-1] >> 30)) + k` modulo 2^32. `ready_o` is low for exactly 624 cycles counted from the first cycle with `rst_n` high, and `valid_o` stays 0 throughout.
- R3: Once `ready_o` is high, it stays high until the next reset.
- R4: `valid_o` is never high while `ready_o` is low. It is a single-cycle pulse. The first pulse comes 3 cycles after `ready_o` rises, and each later pulse comes exactly 3 cycles after the previous one.
- R5: With seed 5489, the first three words are 3499211612, 581869302 and 3890346734.
- R6: Word i of each sweep is built as follows. Take the top bit of state[i] and the low 31 bits of state[(i+1) mod 624]. Shift that 32-bit value right by one. XOR in 0x9908B0DF when its bit 0 was 1. XOR in the current state[(i+397) mod 624]. The result replaces state[i]. It is then tempered in this order: `y ^= y>>11`, `y ^= (y<<7) & 0x9D2C5680`, `y ^= (y<<15) & 0xEFC60000`, `y ^= y>>18`. After index 623 the sweep returns to index 0 with no pause, so the output stream follows the MT19937 sequence across every sweep boundary.
- R7: `data_o` holds its value in every cycle in which `valid_o` is low.
- R8: A reset during generation abandons the current sequence. The block seeds again from the new seed and then produces that seed's sequence from its first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_i | input | 32 | Seed value, sampled while reset is low |
| ready_o | output | 1 | High once seeding has finished |
| valid_o | output | 1 | One-cycle strobe marking a new word on data_o |
| data_o | output | 32 | Tempered random word |

## Verification
Two events meet in the step at index 623. That step rewrites the last state word. In the same step, its neighbour read wraps to word 0, which was already rewritten at the start of the sweep. The neighbour must come from the new word 0, and the value carried into the next sweep must be that same new word. The bench runs more than two full sweeps, so this collision happens twice. Every word is compared against a reference model built only from the recurrence in the requirements, and every gap between strobes is checked to stay at three cycles across the wrap.

// File: rtl/mt_pkg.sv
// Package: shared constants and the output tempering function for the
// Mersenne Twister generator. Assumes a 32-bit word size.
package mt_pkg;
    localparam int unsigned MT_W    = 32;
    localparam int unsigned MT_N    = 624;
    localparam int unsigned MT_M    = 397;

    localparam logic [MT_W-1:0] MT_MATRIX = 32'h9908B0DF;
    localparam logic [MT_W-1:0] MT_MULT   = 32'd1812433253;
    localparam logic [MT_W-1:0] MT_TMASKB = 32'h9D2C5680;
    localparam logic [MT_W-1:0] MT_TMASKC = 32'hEFC60000;

    typedef enum logic {ST_SEED = 1'b0, ST_GEN = 1'b1} mt_mode_e;
    typedef enum logic [1:0] {PH_RD_NEXT = 2'd0, PH_RD_FAR = 2'd1, PH_COMMIT = 2'd2} mt_phase_e;

    // Apply the four tempering shifts in their fixed order.
    function automatic logic [MT_W-1:0] mt_temper(input logic [MT_W-1:0] x);
        logic [MT_W-1:0] y;
        y = x ^ (x >> 11);
        y = y ^ ((y << 7) & MT_TMASKB);
        y = y ^ ((y << 15) & MT_TMASKC);
        y = y ^ (y >> 18);
        return y;
    endfunction
endpackage

// File: rtl/mt_state_ram.sv
// Module: simple dual-port state RAM. One synchronous write port and one
// read port whose data appears one cycle after the address. No reset on the
// array. Assumes DEPTH <= 2**AW.
module mt_state_ram #(
    parameter int unsigned DEPTH = 624,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write port: store a word when enabled.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Read port: registered read, data valid the cycle after the address.
    always_ff @(posedge clk) begin
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/mt_ctrl.sv
// Module: sequencer. It runs one seeding pass (one index per cycle), then
// a three-phase step per index: read neighbour, read far word, commit.
// The index wraps from N-1 to 0 without a pause. Assumes M < N.
module mt_ctrl #(
    parameter int unsigned N = mt_pkg::MT_N,
    parameter int unsigned M = mt_pkg::MT_M,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready_o,
    output logic          seeding_o,
    output logic          load_nxt_o,
    output logic          commit_o,
    output logic [AW-1:0] idx_o,
    output logic [AW-1:0] raddr_o
);
    import mt_pkg::*;

    localparam logic [AW-1:0] IDX_LAST = AW'(N - 1);
    localparam logic [AW-1:0] FAR_WRAP = AW'(N - M);
    localparam logic [AW-1:0] FAR_OFS  = AW'(M);

    mt_mode_e        mode_q;
    mt_phase_e       phase_q;
    logic [AW-1:0]   idx_q;
    logic [AW-1:0]   idx_next;
    logic [AW-1:0]   idx_far;

    // Neighbour and far indices, both taken modulo N.
    always_comb begin
        idx_next = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        idx_far  = (idx_q >= FAR_WRAP) ? idx_q - FAR_WRAP : idx_q + FAR_OFS;
    end

    // Mode, phase and index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= ST_SEED;
            phase_q <= PH_RD_NEXT;
            idx_q   <= '0;
        end else if (mode_q == ST_SEED) begin
            idx_q <= idx_next;
            if (idx_q == IDX_LAST) begin
                mode_q <= ST_GEN;
            end
        end else begin
            case (phase_q)
                PH_RD_NEXT: phase_q <= PH_RD_FAR;
                PH_RD_FAR:  phase_q <= PH_COMMIT;
                default: begin
                    phase_q <= PH_RD_NEXT;
                    idx_q   <= idx_next;
                end
            endcase
        end
    end

    // Decoded controls for the datapath and the RAM read address.
    always_comb begin
        seeding_o  = (mode_q == ST_SEED);
        ready_o    = (mode_q == ST_GEN);
        load_nxt_o = ready_o && (phase_q == PH_RD_FAR);
        commit_o   = ready_o && (phase_q == PH_COMMIT);
        idx_o      = idx_q;
        raddr_o    = (phase_q == PH_RD_NEXT) ? idx_next : idx_far;
    end
endmodule

// File: rtl/mt_datapath.sv
// Module: word datapath. It computes the seeding recurrence (the only
// multiplier), holds the current and neighbour words, forms the twisted
// word and the registered tempered output. Assumes AW < 32.
module mt_datapath #(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   seed_i,
    input  logic          seeding_i,
    input  logic          load_nxt_i,
    input  logic          commit_i,
    input  logic [AW-1:0] idx_i,
    input  logic [31:0]   rdata_i,
    output logic          we_o,
    output logic [31:0]   wdata_o,
    output logic          valid_o,
    output logic [31:0]   data_o
);
    import mt_pkg::*;

    logic [31:0] seed_q;
    logic [31:0] chain_q;
    logic [31:0] cur_q;
    logic [31:0] nxt_q;
    logic [31:0] seed_word;
    logic [31:0] mixed;
    logic [31:0] twisted;

    // Seeding recurrence: word 0 is the seed, later words chain by multiply.
    always_comb begin
        if (idx_i == '0) begin
            seed_word = seed_q;
        end else begin
            seed_word = MT_MULT * (chain_q ^ (chain_q >> 30)) + {{(32-AW){1'b0}}, idx_i};
        end
    end

    // Twist: top bit of current word with low bits of neighbour, plus far word.
    always_comb begin
        mixed   = {cur_q[31], nxt_q[30:0]};
        twisted = (mixed >> 1) ^ (mixed[0] ? MT_MATRIX : '0) ^ rdata_i;
    end

    // RAM write selection between seeding and commit.
    always_comb begin
        we_o    = seeding_i || commit_i;
        wdata_o = seeding_i ? seed_word : twisted;
    end

    // Seed capture during reset and the word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q  <= seed_i;
            chain_q <= '0;
            cur_q   <= '0;
            nxt_q   <= '0;
        end else if (seeding_i) begin
            chain_q <= seed_word;
            cur_q   <= seed_q;
        end else begin
            if (load_nxt_i) begin
                nxt_q <= rdata_i;
            end
            if (commit_i) begin
                cur_q <= nxt_q;
            end
        end
    end

    // Output register: tempered word and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= commit_i;
            if (commit_i) begin
                data_o <= mt_temper(twisted);
            end
        end
    end
endmodule

// File: rtl/mt19937_gen.sv
// Module: top of the Mersenne Twister generator. It joins the sequencer,
// the datapath and the state RAM. The seed is sampled while rst_n is low.
// After N seeding cycles it emits one word every three cycles.
module mt19937_gen #(
    parameter int unsigned N = mt_pkg::MT_N,
    parameter int unsigned M = mt_pkg::MT_M
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] seed_i,
    output logic        ready_o,
    output logic        valid_o,
    output logic [31:0] data_o
);
    localparam int unsigned AW = $clog2(N);

    logic          seeding;
    logic          load_nxt;
    logic          commit;
    logic [AW-1:0] idx;
    logic [AW-1:0] raddr;
    logic          we;
    logic [31:0]   wdata;
    logic [31:0]   rdata;

    mt_ctrl #(.N(N), .M(M)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_o   (ready_o),
        .seeding_o (seeding),
        .load_nxt_o(load_nxt),
        .commit_o  (commit),
        .idx_o     (idx),
        .raddr_o   (raddr)
    );

    mt_datapath #(.AW(AW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_i    (seed_i),
        .seeding_i (seeding),
        .load_nxt_i(load_nxt),
        .commit_i  (commit),
        .idx_i     (idx),
        .rdata_i   (rdata),
        .we_o      (we),
        .wdata_o   (wdata),
        .valid_o   (valid_o),
        .data_o    (data_o)
    );

    mt_state_ram #(.DEPTH(N), .WIDTH(32)) u_ram (
        .clk    (clk),
        .we_i   (we),
        .waddr_i(idx),
        .wdata_i(wdata),
        .raddr_i(raddr),
        .rdata_o(rdata)
    );
endmodule

// File: rtl/mt19937_gen_chk.sv
// Module: protocol checker bound to the generator. It watches the ready
// flag, the strobe cadence and output holding, using only top-level ports.
module mt19937_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ready_o,
    input logic        valid_o,
    input logic [31:0] data_o
);
    logic [2:0] gap_q;
    logic       seen_q;

    // Count cycles since the last strobe (saturating) for the cadence check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (valid_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 3'd7) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!valid_o && !ready_o && data_o == '0)); // R1
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ready_o |=> ready_o); // R3
    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> ready_o); // R4
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o); // R4
    AST_CADENCE: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && seen_q) |-> (gap_q == 3'd2)); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> $stable(data_o)); // R7
endmodule

bind mt19937_gen mt19937_gen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready_o(ready_o),
    .valid_o(valid_o),
    .data_o (data_o)
);

// File: tb/sim_mt19937_gen.sv
// Bench: directed scenarios for the generator. A reference model built from
// the requirements supplies the expected words.
module sim_mt19937_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] seed = 32'd5489;
    logic        ready_o;
    logic        valid_o;
    logic [31:0] data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mref [624];
    int          midx;

    always #4 clk = ~clk;

    mt19937_gen u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed),
        .ready_o(ready_o),
        .valid_o(valid_o),
        .data_o (data_o)
    );

    // Record one check and report it when it fails.
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tb_temper(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v >> 11);
        t = t ^ ((t << 7) & 32'h9D2C5680);
        t = t ^ ((t << 15) & 32'hEFC60000);
        t = t ^ (t >> 18);
        return t;
    endfunction

    // Reference seeding per R2.
    task automatic model_seed(input logic [31:0] s);
        mref[0] = s;
        for (int k = 1; k < 624; k++) begin
            mref[k] = 32'd1812433253 * (mref[k-1] ^ (mref[k-1] >> 30)) + 32'(k);
        end
        midx = 624;
    endtask

    // Reference next word per R6: twist a whole sweep, then temper in order.
    task automatic model_next(output logic [31:0] v);
        logic [31:0] y;
        if (midx >= 624) begin
            for (int k = 0; k < 624; k++) begin
                y = {mref[k][31], mref[(k + 1) % 624][30:0]};
                mref[k] = mref[(k + 397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908B0DF : 32'h0);
            end
            midx = 0;
        end
        v = tb_temper(mref[midx]);
        midx++;
    endtask

    // Step to the next strobe, tracking the gap, output hold and ready.
    task automatic next_valid(output int gap, output bit held, output bit rdy);
        logic [31:0] last;
        last = data_o;
        gap  = 0;
        held = 1'b1;
        rdy  = 1'b1;
        do begin
            @(negedge clk);
            gap++;
            if (!ready_o) rdy = 1'b0;
            if (!valid_o && data_o != last) held = 1'b0;
        end while (!valid_o && gap < 20);
    endtask

    // Scenario: hold reset with a seed and check the idle outputs (R1).
    task automatic t_reset(input logic [31:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        seed  = s;
        repeat (4) @(negedge clk);
        check(ready_o == 1'b0, "R1 ready in reset", 32'(ready_o), 32'd0);
        check(valid_o == 1'b0, "R1 valid in reset", 32'(valid_o), 32'd0);
        check(data_o == 32'd0, "R1 data in reset", data_o, 32'd0);
        rst_n = 1'b1;
    endtask

    // Scenario: seeding length, no strobes, first strobe 3 cycles on (R2, R4).
    task automatic t_seeding();
        int cnt;
        int n;
        bit vseen;
        cnt   = 0;
        vseen = 1'b0;
        while (!ready_o && cnt < 2000) begin
            if (valid_o) vseen = 1'b1;
            cnt++;
            @(negedge clk);
        end
        check(cnt == 624, "R2 seeding cycles", 32'(cnt), 32'd624);
        check(vseen == 1'b0, "R2 no strobe while seeding", 32'(vseen), 32'd0);
        n = 0;
        while (!valid_o && n < 20) begin
            n++;
            @(negedge clk);
        end
        check(n == 3, "R4 first strobe after ready", 32'(n), 32'd3);
    endtask

    // Scenario: published first words for seed 5489 (R5).
    task automatic t_reference();
        logic [31:0] known [3];
        logic [31:0] e;
        int gap;
        bit held;
        bit rdy;
        known[0] = 32'd3499211612;
        known[1] = 32'd581869302;
        known[2] = 32'd3890346734;
        for (int j = 0; j < 3; j++) begin
            model_next(e);
            check(data_o == known[j], "R5 reference word", data_o, known[j]);
            check(data_o == e, "R6 model word", data_o, e);
            next_valid(gap, held, rdy);
            check(gap == 3, "R4 strobe gap", 32'(gap), 32'd3);
        end
    endtask

    // Scenario: long stream across sweep wraps (R6, R4, R3, R7).
    task automatic t_stream(input int n, input string tag);
        logic [31:0] e;
        int gap;
        bit held;
        bit rdy;
        for (int j = 0; j < n; j++) begin
            model_next(e);
            check(data_o == e, tag, data_o, e);
            next_valid(gap, held, rdy);
            check(gap == 3, "R4 strobe gap", 32'(gap), 32'd3);
            check(held, "R7 data held between strobes", 32'(held), 32'd1);
            check(rdy, "R3 ready stays high", 32'(rdy), 32'd1);
        end
    endtask

    // Scenario: reset mid-stream with a new seed restarts that sequence (R8).
    task automatic t_reseed(input logic [31:0] s);
        t_reset(s);
        t_seeding();
        model_seed(s);
        t_stream(700, "R8 new seed sequence");
    endtask

    initial begin
        t_reset(32'd5489);
        t_seeding();
        model_seed(32'd5489);
        t_reference();
        t_stream(1300, "R6 stream across wrap");
        t_reseed(32'h1234_5678);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule